// File: doc/BRIEF.md
# Jump Target and Link Unit

This combinational unit serves the two unconditional jump instructions of a 32-bit integer pipeline. It receives the fetched instruction word, the address of that instruction and the value read from the first source register. From these it produces the address to jump to, the return address to be written to the destination register, and that register's index. It also produces the decoded offset and a flag that marks the word as a jump.

The pc-relative form carries a 20-bit offset field. Its bits sit in the instruction in an order that differs from their weight, so the unit puts them back in order, adds an implied zero below them and sign-extends the result. The register-indirect form adds a sign-extended 12-bit immediate to the register value and always clears bit 0 of the sum. Words that are not jumps leave every output at zero, so a downstream stage can OR or gate the results without a separate qualifier.

Top module: `jump_link_unit`

## Requirements
- R1: For a recognised jump, `link_o` equals `pc_i + 4` and `rd_o` equals instruction bits [11:7].
- R2: For the pc-relative jump (opcode bits [6:0] = 1101111), `offset_o` is built as follows. Bits 19..12 come from instruction bits 19..12. Bit 11 comes from instruction bit 20. Bits 10..1 come from instruction bits 30..21. Bit 0 is 0. The value is then sign-extended. `target_o` equals `pc_i + offset_o`.
- R3: For the pc-relative jump, bit 0 of `offset_o` is always 0, so the reachable offsets are the even values from -1048576 to 1048574.
- R4: For the register-indirect jump (opcode 1100111 with funct3, bits [14:12], equal to 000), `offset_o` is instruction bits [31:20] sign-extended. `target_o` is `rs1_i + offset_o` with bit 0 forced to 0.
- R5: `jump_o` is high exactly for opcode 1101111, and for opcode 1100111 with funct3 000.
- R6: When `jump_o` is low, `target_o`, `link_o`, `offset_o` and `rd_o` are all zero. This includes opcode 1100111 with a nonzero funct3.
- R7: The sign of both offsets is taken from instruction bit 31, so a negative offset moves the target below `pc_i` or `rs1_i`.
- R8: The word 0x000002EF at address 0x10 is a pc-relative jump with a zero offset. It yields target 0x10, link 0x14 and rd 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| rs1_i | input | XLEN | First source register value |
| jump_o | output | 1 | Word is an unconditional jump |
| target_o | output | XLEN | Jump destination address |
| link_o | output | XLEN | Return address for rd |
| rd_o | output | 5 | Destination register index |
| offset_o | output | XLEN | Decoded, sign-extended offset |

## Verification
The unit holds no state, so a fault in it shows up at the outputs in the same cycle as the instruction that triggers it. A misplaced offset bit moves the target by a power of two, but only when that bit is set in the chosen field. The stimulus therefore sets each field group on its own, and also uses the extreme offsets of both signs. A missing bit-0 clear shows up only for an odd register-indirect sum, and a loose funct3 decode shows up only for an opcode match with a nonzero funct3. Both cases are driven on purpose.

// File: rtl/jlu_pkg.sv
package jlu_pkg;
  localparam int INSN_W = 32;
  localparam int REG_IDX_W = 5;
  localparam int JOFF_W = 21;
  localparam int IOFF_W = 12;

  localparam logic [6:0] OPC_JAL  = 7'b1101111;
  localparam logic [6:0] OPC_JALR = 7'b1100111;
  localparam logic [2:0] F3_JALR  = 3'b000;

  typedef enum logic [1:0] {
    JK_NONE = 2'd0,
    JK_PCREL = 2'd1,
    JK_REGIND = 2'd2
  } jkind_e;
endpackage

// File: rtl/jlu_imm_decode.sv
module jlu_imm_decode
  import jlu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSN_W-1:12] upper_i,
  output logic [XLEN-1:0]    imm_pcrel_o,
  output logic [XLEN-1:0]    imm_regind_o
);
  localparam int JEXT = XLEN - (JOFF_W - 1);
  localparam int IEXT = XLEN - IOFF_W;

  // Offset field for the pc-relative jump, put back in weight order.
  always_comb begin
    imm_pcrel_o = {{JEXT{upper_i[31]}}, upper_i[19:12], upper_i[20],
                   upper_i[30:21], 1'b0};
  end

  // 12-bit immediate for the register-indirect jump.
  always_comb begin
    imm_regind_o = {{IEXT{upper_i[31]}}, upper_i[31:20]};
  end
endmodule

// File: rtl/jlu_classify.sv
module jlu_classify
  import jlu_pkg::*;
(
  input  logic [6:0] opcode_i,
  input  logic [2:0] funct3_i,
  output jkind_e     kind_o
);
  always_comb begin
    kind_o = JK_NONE;
    if (opcode_i == OPC_JAL) begin
      kind_o = JK_PCREL;
    end else if (opcode_i == OPC_JALR && funct3_i == F3_JALR) begin
      kind_o = JK_REGIND;
    end
  end
endmodule

// File: rtl/jlu_target.sv
module jlu_target
  import jlu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  jkind_e          kind_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] imm_pcrel_i,
  input  logic [XLEN-1:0] imm_regind_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] link_o,
  output logic [XLEN-1:0] offset_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_W / 8);
  localparam logic [XLEN-1:0] LSB_CLR = ~XLEN'(1);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] sum;

  always_comb begin
    base = '0;
    offset_o = '0;
    case (kind_i)
      JK_PCREL: begin
        base = pc_i;
        offset_o = imm_pcrel_i;
      end
      JK_REGIND: begin
        base = rs1_i;
        offset_o = imm_regind_i;
      end
      default: begin
        base = '0;
        offset_o = '0;
      end
    endcase
  end

  assign sum = base + offset_o;

  always_comb begin
    target_o = '0;
    link_o = '0;
    if (kind_i == JK_PCREL) begin
      target_o = sum;
      link_o = pc_i + STEP;
    end else if (kind_i == JK_REGIND) begin
      target_o = sum & LSB_CLR;
      link_o = pc_i + STEP;
    end
  end
endmodule

// File: rtl/jump_link_unit.sv
module jump_link_unit
  import jlu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSN_W-1:0]    insn_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic [XLEN-1:0]      rs1_i,
  output logic                 jump_o,
  output logic [XLEN-1:0]      target_o,
  output logic [XLEN-1:0]      link_o,
  output logic [REG_IDX_W-1:0] rd_o,
  output logic [XLEN-1:0]      offset_o
);
  jkind_e          kind;
  logic [XLEN-1:0] imm_pcrel;
  logic [XLEN-1:0] imm_regind;

  jlu_classify u_classify (
    .opcode_i (insn_i[6:0]),
    .funct3_i (insn_i[14:12]),
    .kind_o   (kind)
  );

  jlu_imm_decode #(.XLEN(XLEN)) u_imm (
    .upper_i      (insn_i[INSN_W-1:12]),
    .imm_pcrel_o  (imm_pcrel),
    .imm_regind_o (imm_regind)
  );

  jlu_target #(.XLEN(XLEN)) u_target (
    .kind_i       (kind),
    .pc_i         (pc_i),
    .rs1_i        (rs1_i),
    .imm_pcrel_i  (imm_pcrel),
    .imm_regind_i (imm_regind),
    .target_o     (target_o),
    .link_o       (link_o),
    .offset_o     (offset_o)
  );

  assign jump_o = (kind != JK_NONE);
  assign rd_o = jump_o ? insn_i[11:7] : '0;
endmodule

// File: rtl/jump_link_unit_chk.sv
module jump_link_unit_chk #(
  parameter int XLEN = 32
) (
  input logic [31:0]     insn_i,
  input logic [XLEN-1:0] pc_i,
  input logic            jump_o,
  input logic [XLEN-1:0] target_o,
  input logic [XLEN-1:0] link_o,
  input logic [4:0]      rd_o,
  input logic [XLEN-1:0] offset_o
);
  always_comb begin
    if (!$isunknown(insn_i) && !$isunknown(pc_i)) begin
      // R5
      jal_flag_chk: assert (insn_i[6:0] != 7'b1101111 || jump_o);
      // R6
      idle_zero_chk: assert (jump_o || (target_o == '0 && link_o == '0 &&
                                        rd_o == '0 && offset_o == '0));
      // R3
      pcrel_even_chk: assert (insn_i[6:0] != 7'b1101111 || !offset_o[0]);
      // R4
      regind_lsb_chk: assert (!(insn_i[6:0] == 7'b1100111 && jump_o) ||
                              !target_o[0]);
      // R7
      sign_src_chk: assert (!jump_o || offset_o[XLEN-1] == insn_i[31]);
      // R1
      link_step_chk: assert (!jump_o || link_o - pc_i == XLEN'(4));
    end
  end
endmodule

bind jump_link_unit jump_link_unit_chk #(.XLEN(XLEN)) u_chk (
  .insn_i   (insn_i),
  .pc_i     (pc_i),
  .jump_o   (jump_o),
  .target_o (target_o),
  .link_o   (link_o),
  .rd_o     (rd_o),
  .offset_o (offset_o)
);

// File: tb/jump_link_unit_bench.sv
module jump_link_unit_bench;
  localparam int XLEN = 32;

  logic            clk;
  logic            rst_n;
  logic [31:0]     insn;
  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] rs1;
  logic            jump;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] link;
  logic [4:0]      rd;
  logic [XLEN-1:0] offset;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [31:0] e_tgt;
    logic [31:0] e_link;
    logic [31:0] e_off;
    logic [4:0]  e_rd;
    logic        e_jmp;
  } item_t;

  item_t sb[$];

  jump_link_unit #(.XLEN(XLEN)) u_jump_link_unit (
    .insn_i (insn), .pc_i (pc), .rs1_i (rs1), .jump_o (jump),
    .target_o (target), .link_o (link), .rd_o (rd), .offset_o (offset)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_pcrel(int off, logic [4:0] rdi);
    logic [20:0] o = 21'(off);
    return {o[20], o[10:1], o[11], o[19:12], rdi, 7'b1101111};
  endfunction

  function automatic logic [31:0] enc_regind(logic [11:0] imm, logic [2:0] f3,
                                             logic [4:0] rdi);
    return {imm, 5'd3, f3, rdi, 7'b1100111};
  endfunction

  task automatic drive(string tag, logic [31:0] w, logic [31:0] p, logic [31:0] r,
                       logic jmp, logic [31:0] off, logic [31:0] tgt);
    item_t it;
    @(posedge clk);
    insn = w; pc = p; rs1 = r;
    it.tag = tag;
    it.e_jmp = jmp;
    it.e_off = jmp ? off : 32'h0;
    it.e_tgt = jmp ? tgt : 32'h0;
    it.e_link = jmp ? p + 32'd4 : 32'h0;
    it.e_rd = jmp ? w[11:7] : 5'd0;
    sb.push_back(it);
  endtask

  // Monitor: results of the cycle's inputs are sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(it.tag, "jump", {31'b0, jump}, {31'b0, it.e_jmp});
      chk(it.tag, "target", target, it.e_tgt);
      chk(it.tag, "link", link, it.e_link);
      chk(it.tag, "rd", {27'b0, rd}, {27'b0, it.e_rd});
      chk(it.tag, "offset", offset, it.e_off);
    end
  end

  task automatic pcrel(string tag, int off, logic [31:0] p);
    drive(tag, enc_pcrel(off, 5'd1), p, 32'h0, 1'b1, 32'(off), p + 32'(off));
  endtask

  task automatic regind(string tag, logic [11:0] imm, logic [31:0] r);
    logic [31:0] s = {{20{imm[11]}}, imm};
    drive(tag, enc_regind(imm, 3'b000, 5'd7), 32'h400, r, 1'b1, s,
          (r + s) & ~32'h1);
  endtask

  initial begin
    rst_n = 0;
    insn = 32'h0; pc = 32'h0; rs1 = 32'h0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R6 all-zero word after reset: idle outputs
    drive("R6_idle", 32'h0, 32'h100, 32'h55, 1'b0, 0, 0);
    // R8 known encoding
    drive("R8_self", 32'h000002ef, 32'h10, 32'h0, 1'b1, 32'h0, 32'h10);
    // R2 each field group alone
    pcrel("R2_bit11", 32'h800, 32'h1000);
    pcrel("R2_hi", 32'h55000, 32'h2000);
    pcrel("R2_lo", 32'h556, 32'h3000);
    pcrel("R2_max", 1048574, 32'h0);
    // R7 negative offsets
    pcrel("R7_min", -1048576, 32'h00200000);
    pcrel("R7_m2", -2, 32'h100);
    // R3 all offset bits set in the field: bit 0 stays 0
    drive("R3_allones", 32'hFFFFF06F, 32'h40, 32'h0, 1'b1, 32'hFFFFFFFE, 32'h3E);
    // R4 register-indirect
    regind("R4_odd", 12'h000, 32'h1001);
    regind("R4_m1", 12'hFFF, 32'h2000);
    regind("R4_max", 12'h7FF, 32'h100);
    regind("R7_regmin", 12'h800, 32'h80000000);
    // R5 R6 opcode match with bad funct3, and a branch opcode
    drive("R5_f3", enc_regind(12'h010, 3'b001, 5'd4), 32'h80, 32'h9, 1'b0, 0, 0);
    drive("R6_branch", 32'h00208463, 32'h80, 32'h9, 1'b0, 0, 0);
    // R1 link at high address
    pcrel("R1_wrap", 16, 32'hFFFFFFF0);
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule